// File: doc/BRIEF.md
# Serial Port Baud and Bit-Clock Generator

This block produces the bit-rate timing for a serial transmitter and receiver that can run asynchronously, as a synchronous master, or as a synchronous slave. A reloadable down-counter clocked by the system clock turns a 12-bit rate value into a baud tick once every RATE+1 cycles. In the two internal-clock modes, the receiver enable is that tick. The transmitter enable is the tick divided by 16, 8 or 2. Which divider applies depends on the mode and the double-speed bit.

In synchronous master mode the block drives a square bit clock on the serial clock pin. The pin clock spans two baud ticks. In synchronous slave mode the block ignores the internal ticks and listens to the pin instead. The pin is passed through a two-stage synchronizer, and the edge selected by the polarity bit produces a one-cycle enable on both the transmit and receive outputs. A write strobe for the rate register's low byte reloads the counter at once and drops any count in progress.

Top module: `serclk_gen`

## Requirements
- R1: In asynchronous and synchronous master modes, rx_en_o pulses for one cycle every RATE+1 system clock cycles, where RATE is rate_i (RATE=0 gives a pulse every cycle).
- R2: A cycle with rate_lo_wr_i high loads the counter with rate_i and gives no pulse in that cycle. The next rx_en_o comes RATE+1 cycles after the write cycle, whatever count was in progress.
- R3: In asynchronous mode with dbl_speed_i low, tx_en_o pulses once every 16 baud ticks, and only in a cycle where rx_en_o is also high.
- R4: In asynchronous mode with dbl_speed_i high, tx_en_o pulses once every 8 baud ticks.
- R5: In synchronous master mode (sync_mode_i=1, pin_dir_i=1), tx_en_o pulses once every 2 baud ticks, and dbl_speed_i has no effect.
- R6: In synchronous master mode, xclk_o is high for one baud period and low for the next. It is low in the cycle after each tx_en_o pulse.
- R7: xclk_o stays low whenever the mode is not synchronous master.
- R8: In synchronous slave mode (sync_mode_i=1, pin_dir_i=0), tx_en_o equals rx_en_o. Each is a one-cycle pulse per rising edge of xclk_i when clk_pol_i=0, or per falling edge when clk_pol_i=1. The pulse is visible in the second cycle after the edge has been clocked in.
- R9: In asynchronous mode, changes on xclk_i have no effect on the outputs.
- R10: While rst_n is low, tx_en_o, rx_en_o and xclk_o are all low.
- R11: In synchronous slave mode, baud ticks do not reach the outputs. With xclk_i held steady, no enables appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_i | input | 12 | Baud divisor value RATE |
| rate_lo_wr_i | input | 1 | Low-byte write strobe, forces counter reload |
| sync_mode_i | input | 1 | 1 = synchronous, 0 = asynchronous |
| dbl_speed_i | input | 1 | Asynchronous double speed (/8 instead of /16) |
| pin_dir_i | input | 1 | Clock pin direction: 1 = master drives, 0 = slave reads |
| clk_pol_i | input | 1 | Slave edge select: 0 = rising, 1 = falling |
| xclk_i | input | 1 | Serial clock pin input |
| tx_en_o | output | 1 | One-cycle transmit enable |
| rx_en_o | output | 1 | One-cycle receive enable |
| xclk_o | output | 1 | Serial clock pin output |

## Verification
The bound checker watches, on every cycle, the relations that must never break. These are: the idle-low pin outside master mode, transmit enables landing only on baud ticks, the pin falling after each master transmit enable, no pulse right after a reload with a nonzero rate, and identical single-cycle enables in slave mode. The exact spacings can only be shown by the bench scenarios. These cover the /16, /8 and /2 intervals at several rates, the reload distance after a mid-count write, the two-edge slave latency for each polarity, and the absence of any effect from the pin in asynchronous mode.

// File: rtl/serclk_pkg.sv
// Shared types and helpers for the serial clock generator.
// Assumes the three control bits are stable between configuration changes.
package serclk_pkg;

    typedef enum logic [1:0] {
        CM_ASYNC_NORM  = 2'd0,
        CM_ASYNC_DBL   = 2'd1,
        CM_SYNC_MASTER = 2'd2,
        CM_SYNC_SLAVE  = 2'd3
    } clk_mode_e;

    // Map the raw control bits onto an operating mode.
    function automatic clk_mode_e decode_mode(input logic sync_b,
                                              input logic dbl_b,
                                              input logic dir_b);
        if (sync_b)
            return dir_b ? CM_SYNC_MASTER : CM_SYNC_SLAVE;
        return dbl_b ? CM_ASYNC_DBL : CM_ASYNC_NORM;
    endfunction

    // Post-divider ratio that applies to a mode (slave does not use it).
    function automatic logic [4:0] div_ratio(input clk_mode_e m);
        case (m)
            CM_ASYNC_NORM:  return 5'd16;
            CM_ASYNC_DBL:   return 5'd8;
            default:        return 5'd2;
        endcase
    endfunction

endpackage

// File: rtl/serclk_baud_cnt.sv
// Reloadable baud down-counter.
// Counts down on every system clock. It reloads from rate_i on zero or on load_i.
// It flags a tick for each zero it reaches. The tick is masked in the first
// cycle after reset and in any load cycle.
module serclk_baud_cnt #(
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              load_i,
    output logic              tick_o
);
    logic [RATE_W-1:0] cnt_q;
    logic              run_q;
    logic              at_zero;

    assign at_zero = (cnt_q == '0);

    // Down-count with reload on zero or on a rate write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i || at_zero)
            cnt_q <= rate_i;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    // Mark that the counter has left reset so the cleared value is no tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= 1'b1;
    end

    // Tick decode: a real zero, not the reset value and not discarded by a write.
    always_comb begin
        tick_o = run_q && at_zero && !load_i;
    end
endmodule

// File: rtl/serclk_postdiv.sv
// Transmit post-divider.
// Counts baud ticks modulo ratio_i and pulses tx_o on the last tick of each
// group. phase_o is high in the upper half of the group, which gives the
// master pin waveform for a /2 ratio. A counter left beyond a smaller ratio
// after a mode change wraps on the next tick.
module serclk_postdiv #(
    parameter int MAX_DIV = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic [$clog2(MAX_DIV):0]   ratio_i,
    output logic                       tx_o,
    output logic                       phase_o
);
    localparam int CNT_W = $clog2(MAX_DIV);
    localparam int RAT_W = CNT_W + 1;

    logic [CNT_W-1:0] grp_q;
    logic [RAT_W-1:0] grp_ext;
    logic             last_tick;

    assign grp_ext   = {1'b0, grp_q};
    assign last_tick = (grp_ext >= (ratio_i - 1'b1));

    // Advance the group position on each tick, wrapping at the ratio.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grp_q <= '0;
        else if (tick_i)
            grp_q <= last_tick ? '0 : grp_q + 1'b1;
    end

    // Output decode: transmit pulse on the final tick, phase in the upper half.
    always_comb begin
        tx_o    = tick_i && last_tick;
        phase_o = (grp_ext >= (ratio_i >> 1));
    end
endmodule

// File: rtl/serclk_edge_det.sv
// External clock synchronizer and edge detector.
// Passes the pin through STAGES flip-flops, keeps one more stage as history,
// and pulses for one cycle on the edge chosen by fall_sel_i
// (0 rising, 1 falling). Assumes the pin is slower than a quarter of clk.
module serclk_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    logic chain [0:STAGES];

    // First synchronizer stage samples the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain[0] <= 1'b0;
        else
            chain[0] <= pin_i;
    end

    // Remaining synchronizer stages plus the history stage.
    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain[g] <= 1'b0;
            else
                chain[g] <= chain[g-1];
        end
    end

    // Edge compare between the synchronized level and its history.
    always_comb begin
        if (fall_sel_i)
            edge_o = !chain[STAGES-1] && chain[STAGES];
        else
            edge_o = chain[STAGES-1] && !chain[STAGES];
    end
endmodule

// File: rtl/serclk_gen.sv
// Serial port clock generator (top).
// Baud down-counter, then a mode-selected transmit divider, then a choice
// between internal timing and the synchronized external pin clock.
// Assumes the mode bits change only while the serial port is idle.
module serclk_gen #(
    parameter int RATE_W      = 12,
    parameter int MAX_DIV     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              rate_lo_wr_i,
    input  logic              sync_mode_i,
    input  logic              dbl_speed_i,
    input  logic              pin_dir_i,
    input  logic              clk_pol_i,
    input  logic              xclk_i,
    output logic              tx_en_o,
    output logic              rx_en_o,
    output logic              xclk_o
);
    import serclk_pkg::*;

    localparam int RAT_W = $clog2(MAX_DIV) + 1;

    clk_mode_e        mode;
    logic             internal_clk;
    logic [RAT_W-1:0] ratio;
    logic             baud_tick;
    logic             div_tick;
    logic             div_tx;
    logic             div_phase;
    logic             ext_edge;

    // Mode decode and divider selection.
    always_comb begin
        mode         = decode_mode(sync_mode_i, dbl_speed_i, pin_dir_i);
        internal_clk = (mode != CM_SYNC_SLAVE);
        ratio        = RAT_W'(div_ratio(mode));
        div_tick     = baud_tick && internal_clk;
    end

    serclk_baud_cnt #(.RATE_W(RATE_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .rate_i (rate_i),
        .load_i (rate_lo_wr_i),
        .tick_o (baud_tick)
    );

    serclk_postdiv #(.MAX_DIV(MAX_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (div_tick),
        .ratio_i (ratio),
        .tx_o    (div_tx),
        .phase_o (div_phase)
    );

    serclk_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (xclk_i),
        .fall_sel_i (clk_pol_i),
        .edge_o     (ext_edge)
    );

    // Output select: internal timing, or pin edges in slave mode.
    always_comb begin
        rx_en_o = internal_clk ? baud_tick : ext_edge;
        tx_en_o = internal_clk ? div_tx    : ext_edge;
        xclk_o  = (mode == CM_SYNC_MASTER) ? div_phase : 1'b0;
    end
endmodule

// File: rtl/serclk_checker.sv
// Cycle-level property checker for serclk_gen, attached with bind.
// Observes ports only.
module serclk_checker #(
    parameter int RATE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RATE_W-1:0] rate_i,
    input logic              rate_lo_wr_i,
    input logic              sync_mode_i,
    input logic              pin_dir_i,
    input logic              tx_en_o,
    input logic              rx_en_o,
    input logic              xclk_o
);
    logic is_slave;
    logic is_master;
    assign is_slave  = sync_mode_i && !pin_dir_i;
    assign is_master = sync_mode_i && pin_dir_i;

    assert_pin_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> !xclk_o);

    assert_tx_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_slave && tx_en_o) |-> rx_en_o);

    assert_slave_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_slave |-> (tx_en_o == rx_en_o));

    assert_slave_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_slave && rx_en_o) |=> (!is_slave || !rx_en_o));

    assert_reload_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_lo_wr_i && rate_i != '0) |=> (is_slave || !rx_en_o));

    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_slave && rx_en_o && rate_i != '0) |=> (is_slave || !rx_en_o));

    assert_pin_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && tx_en_o) |=> (!is_master || !xclk_o));
endmodule

bind serclk_gen serclk_checker #(.RATE_W(RATE_W)) u_serclk_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rate_i       (rate_i),
    .rate_lo_wr_i (rate_lo_wr_i),
    .sync_mode_i  (sync_mode_i),
    .pin_dir_i    (pin_dir_i),
    .tx_en_o      (tx_en_o),
    .rx_en_o      (rx_en_o),
    .xclk_o       (xclk_o)
);

// File: tb/test_serclk_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task queues expected pulse spacings and a
// negedge monitor pops and compares them against measured spacings.
module test_serclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] rate_i = 12'd0;
    logic        rate_lo_wr_i = 1'b0;
    logic        sync_mode_i = 1'b0;
    logic        dbl_speed_i = 1'b0;
    logic        pin_dir_i = 1'b0;
    logic        clk_pol_i = 1'b0;
    logic        xclk_i = 1'b0;
    logic        tx_en_o, rx_en_o, xclk_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int exp_q[$];
    string tag_q[$];
    bit sb_on = 0;
    bit mon_tx = 0;
    bit have_last = 0;
    int last_cyc = 0;
    bit toggling = 0;

    always #2 clk = ~clk;

    serclk_gen i_serclk_gen (
        .clk(clk), .rst_n(rst_n), .rate_i(rate_i), .rate_lo_wr_i(rate_lo_wr_i),
        .sync_mode_i(sync_mode_i), .dbl_speed_i(dbl_speed_i), .pin_dir_i(pin_dir_i),
        .clk_pol_i(clk_pol_i), .xclk_i(xclk_i),
        .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .xclk_o(xclk_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: measure pulse spacing on the selected enable and compare.
    always @(negedge clk) begin
        if (sb_on && (mon_tx ? tx_en_o : rx_en_o)) begin
            if (have_last && exp_q.size() > 0)
                check(tag_q.pop_front(), cyc - last_cyc, exp_q.pop_front());
            last_cyc  = cyc;
            have_last = 1;
        end
    end

    // Pin toggler used while the pin must be ignored.
    always @(negedge clk) if (toggling) xclk_i <= ~xclk_i;

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic write_rate(input int r);
        @(negedge clk);
        rate_i = 12'(r);
        rate_lo_wr_i = 1'b1;
        @(negedge clk);
        rate_lo_wr_i = 1'b0;
    endtask

    // Driver: queue n expected spacings on one enable and wait until consumed.
    task automatic expect_period(input bit use_tx, input int spacing, input int n, input string req);
        @(negedge clk);
        mon_tx = use_tx;
        have_last = 0;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(spacing);
            tag_q.push_back(req);
        end
        sb_on = 1;
        while (exp_q.size() != 0) @(negedge clk);
        sb_on = 0;
    endtask

    initial begin
        int cnt;
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 tx", int'(tx_en_o), 0);
        check("R10 rx", int'(rx_en_o), 0);
        check("R10 xclk", int'(xclk_o), 0);
        rst_n = 1'b1;

        // R1 / R3: asynchronous normal speed
        write_rate(5);
        expect_period(0, 6, 5, "R1");
        expect_period(1, 96, 3, "R3");
        write_rate(0);
        expect_period(0, 1, 4, "R1");

        // R4: asynchronous double speed
        dbl_speed_i = 1'b1;
        write_rate(3);
        expect_period(1, 32, 3, "R4");

        // R5 / R6: synchronous master, double-speed bit set and ignored
        sync_mode_i = 1'b1; pin_dir_i = 1'b1;
        write_rate(4);
        expect_period(0, 5, 3, "R1");
        expect_period(1, 10, 3, "R5");
        @(negedge clk);
        while (!tx_en_o) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i == 0) check("R6 low after tx", int'(xclk_o), 0);
            cnt += int'(xclk_o);
        end
        check("R6 high share", cnt, 5);

        // R7 / R9: asynchronous with pin toggling
        sync_mode_i = 1'b0; pin_dir_i = 1'b0; dbl_speed_i = 1'b0;
        write_rate(2);
        toggling = 1;
        expect_period(0, 3, 4, "R9");
        expect_period(1, 48, 2, "R9");
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cnt += int'(xclk_o);
        end
        check("R7 pin idle", cnt, 0);
        toggling = 0;
        @(negedge clk);
        xclk_i = 1'b0;

        // R2: a write mid-count reloads at once
        write_rate(20);
        @(negedge clk);
        while (!rx_en_o) @(negedge clk);
        repeat (5) @(negedge clk);
        rate_i = 12'd9;
        rate_lo_wr_i = 1'b1;
        @(negedge clk);
        rate_lo_wr_i = 1'b0;
        cnt = 1;
        while (!rx_en_o && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        check("R2 reload distance", cnt, 10);

        // R8 / R11: synchronous slave, rising edges
        write_rate(0);
        sync_mode_i = 1'b1; pin_dir_i = 1'b0; clk_pol_i = 1'b0;
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            cnt += int'(rx_en_o) + int'(tx_en_o);
        end
        check("R11 no ticks in slave", cnt, 0);
        xclk_i = 1'b1;
        @(negedge clk); check("R8 rise lat1", int'(rx_en_o), 0);
        @(negedge clk); check("R8 rise lat2", int'(rx_en_o), 1);
        check("R8 tx equals rx", int'(tx_en_o), 1);
        @(negedge clk); check("R8 rise lat3", int'(rx_en_o), 0);
        cnt = 0;
        for (int e = 0; e < 4; e++) begin
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (i == 0) xclk_i = 1'b0;
                if (i == 8) xclk_i = 1'b1;
                cnt += int'(rx_en_o);
            end
        end
        repeat (4) @(negedge clk);
        check("R8 rising count", cnt, 4);

        // R8: falling edges with polarity set
        clk_pol_i = 1'b1;
        @(negedge clk);
        xclk_i = 1'b0;
        @(negedge clk); check("R8 fall lat1", int'(tx_en_o), 0);
        @(negedge clk); check("R8 fall lat2", int'(tx_en_o), 1);
        @(negedge clk); check("R8 fall lat3", int'(tx_en_o), 0);
        xclk_i = 1'b1;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cnt += int'(rx_en_o);
        end
        check("R8 rise ignored with pol=1", cnt, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule